// File: doc/BRIEF.md
# Bus access wait-state inserter

This block lengthens main-processor memory cycles while address translation is in use. Each memory access is signalled by a one-cycle strobe. The block counts these accesses and, when the count reaches the current wait factor, asks the processor for one extra clock. The processor sees that request as a registered, single-cycle pulse.

The wait factor is not a fixed number. It is chosen every cycle from the clock-mode flag and the three translation flags: window remapping, bank remapping and fast-translation mode. In slow clock mode the block does nothing. The counter holds its value and no request is made.

The block also holds a pending I/O-wait flag. An I/O request sets it. A counted memory access clears it. Reset clears it as well.

Top module: `wait_state_inserter`

## Requirements
- R1: While `slow_clk` is 1, strobes produce no `extra_clk` pulse, and the access count keeps its value. Counting resumes from that value once `slow_clk` returns to 0.
- R2: With `slow_clk`=0, `fast_xlat`=0 and `win_en` or `bank_en` at 1, the wait factor is 3: `extra_clk` pulses on every third access.
- R3: With `fast_xlat`=1, the wait factor is 2 whatever `win_en` and `bank_en` are.
- R4: With `win_en`=0 and `bank_en`=0, the wait factor is 2.
- R5: A counted access whose incremented count is at or above the current factor produces a pulse. This includes the case where the factor dropped below the count already held.
- R6: `extra_clk` is high for exactly the one cycle after the clock edge that sampled the triggering strobe. It is low in every cycle that does not follow a counted strobe.
- R7: The count returns to zero on the edge that raises `extra_clk`, so the next pulse needs a full factor of further accesses. This holds under back-to-back strobes.
- R8: Synchronous reset `rst` (active high) clears the access count, `extra_clk` and `io_wait`.
- R9: `io_wait` goes to 1 on the edge after `io_wait_set`=1. It is cleared by a strobe counted with `slow_clk`=0, and a strobe seen while `slow_clk`=1 leaves it set. When `io_wait_set` and a counted strobe arrive in the same cycle, the flag is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_stb | input | 1 | One-cycle strobe per memory access |
| slow_clk | input | 1 | 1 = slow clock mode, no waits inserted |
| win_en | input | 1 | Window remapping enabled |
| bank_en | input | 1 | Bank remapping enabled |
| fast_xlat | input | 1 | Fast-translation mode |
| io_wait_set | input | 1 | Raises the pending I/O-wait flag |
| extra_clk | output | 1 | Registered one-cycle extra-clock request |
| io_wait | output | 1 | Pending I/O-wait flag |

## Verification
Two events can fall in the same cycle. The first pair is a pulse being issued while the counter restarts under an unbroken run of strobes. The bench holds the strobe high for several cycles and expects the pulse pattern 0,1,0,1 with factor 2. The second pair is an I/O-wait set arriving together with a counted access. The bench drives both on one edge and expects `io_wait` to read 1 afterwards. A further case changes the factor from 3 to 2 while the count stands at 2, and checks that the very next access pulses.

// File: rtl/wsi_pkg.sv
package wsi_pkg;
  typedef enum logic [1:0] {
    WM_IDLE  = 2'd0,
    WM_PLAIN = 2'd1,
    WM_XLAT  = 2'd2,
    WM_FAST  = 2'd3
  } wait_mode_t;
endpackage

// File: rtl/wsi_factor_sel.sv
module wsi_factor_sel
  import wsi_pkg::*;
#(
  parameter int unsigned FW       = 2,
  parameter int unsigned F_PLAIN  = 2,
  parameter int unsigned F_XLAT   = 3,
  parameter int unsigned F_FAST   = 2
) (
  input  logic          slow_clk,
  input  logic          win_en,
  input  logic          bank_en,
  input  logic          fast_xlat,
  output wait_mode_t    mode,
  output logic [FW-1:0] factor
);
  always_comb begin
    if (slow_clk)              mode = WM_IDLE;
    else if (fast_xlat)        mode = WM_FAST;
    else if (win_en || bank_en) mode = WM_XLAT;
    else                       mode = WM_PLAIN;
  end

  always_comb begin
    case (mode)
      WM_PLAIN: factor = FW'(F_PLAIN);
      WM_XLAT:  factor = FW'(F_XLAT);
      WM_FAST:  factor = FW'(F_FAST);
      default:  factor = '0;
    endcase
  end
endmodule

// File: rtl/wsi_access_counter.sv
module wsi_access_counter #(
  parameter int unsigned FW = 2,
  localparam int unsigned CW = FW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          count_en,
  input  logic [FW-1:0] factor,
  output logic          pulse_q
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic          hit;

  assign cnt_inc = cnt_q + CW'(1);
  assign hit     = count_en && (factor != '0) && (cnt_inc >= CW'(factor));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit;
      if (hit)
        cnt_q <= '0;
      else if (count_en && (factor != '0))
        cnt_q <= cnt_inc;
    end
  end

  // R7: counter restarts when the request is raised
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> (cnt_q == '0));

  // R1: idle enable keeps the count
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !count_en |=> $stable(cnt_q));
endmodule

// File: rtl/wait_state_inserter.sv
module wait_state_inserter
  import wsi_pkg::*;
#(
  parameter int unsigned F_PLAIN = 2,
  parameter int unsigned F_XLAT  = 3,
  parameter int unsigned F_FAST  = 2,
  localparam int unsigned F_MAX0 = (F_PLAIN > F_XLAT) ? F_PLAIN : F_XLAT,
  localparam int unsigned F_MAX  = (F_MAX0 > F_FAST) ? F_MAX0 : F_FAST,
  localparam int unsigned FW     = $clog2(F_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_stb,
  input  logic slow_clk,
  input  logic win_en,
  input  logic bank_en,
  input  logic fast_xlat,
  input  logic io_wait_set,
  output logic extra_clk,
  output logic io_wait
);
  wait_mode_t    mode;
  logic [FW-1:0] factor;
  logic          counted;
  logic          io_wait_q;

  assign counted = acc_stb && !slow_clk;

  wsi_factor_sel #(
    .FW(FW), .F_PLAIN(F_PLAIN), .F_XLAT(F_XLAT), .F_FAST(F_FAST)
  ) u_sel (
    .slow_clk (slow_clk),
    .win_en   (win_en),
    .bank_en  (bank_en),
    .fast_xlat(fast_xlat),
    .mode     (mode),
    .factor   (factor)
  );

  wsi_access_counter #(.FW(FW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .count_en(counted),
    .factor  (factor),
    .pulse_q (extra_clk)
  );

  always_ff @(posedge clk) begin
    if (rst)              io_wait_q <= 1'b0;
    else if (io_wait_set) io_wait_q <= 1'b1;
    else if (counted)     io_wait_q <= 1'b0;
  end
  assign io_wait = io_wait_q;

  // R1: slow mode never requests an extra clock
  a_r1_slow_quiet: assert property (@(posedge clk) disable iff (rst)
    (slow_clk || !acc_stb) |=> !extra_clk);

  // R2: translation without fast mode picks the large factor
  a_r2_xlat_factor: assert property (@(posedge clk) disable iff (rst)
    (!slow_clk && !fast_xlat && (win_en || bank_en)) |-> (factor == FW'(F_XLAT)));

  // R3: fast mode picks its own factor
  a_r3_fast_factor: assert property (@(posedge clk) disable iff (rst)
    (!slow_clk && fast_xlat) |-> (factor == FW'(F_FAST)));

  // R6: a pulse always follows a counted strobe
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    extra_clk |-> $past(counted));

  // R8: reset leaves request and flag low
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!extra_clk && !io_wait));

  // R9: a set request always leaves the flag high
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    io_wait_set |=> io_wait);
endmodule

// File: tb/wait_state_inserter_test.sv
module wait_state_inserter_test;
  logic clk = 1'b0;
  logic rst, acc_stb, slow_clk, win_en, bank_en, fast_xlat, io_wait_set;
  logic extra_clk, io_wait;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  wait_state_inserter uut (
    .clk(clk), .rst(rst), .acc_stb(acc_stb), .slow_clk(slow_clk),
    .win_en(win_en), .bank_en(bank_en), .fast_xlat(fast_xlat),
    .io_wait_set(io_wait_set), .extra_clk(extra_clk), .io_wait(io_wait)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic set_mode(input logic s, input logic w, input logic b, input logic f);
    @(negedge clk);
    slow_clk = s; win_en = w; bank_en = b; fast_xlat = f;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; acc_stb = 1'b0; io_wait_set = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one access; returns extra_clk just after the sampling edge
  task automatic access(output logic p);
    @(negedge clk);
    acc_stb = 1'b1;
    @(posedge clk);
    #1 p = extra_clk;
    @(negedge clk);
    acc_stb = 1'b0;
  endtask

  task automatic run_pattern(input string req, input int n, input int period);
    logic p;
    for (int i = 1; i <= n; i++) begin
      access(p);
      check(req, p, (i % period) == 0);
    end
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R8 reset extra_clk", extra_clk, 1'b0);
    check("R8 reset io_wait", io_wait, 1'b0);
  endtask

  task automatic t_plain();
    do_reset();
    set_mode(0, 0, 0, 0);
    run_pattern("R4 plain factor", 4, 2);
  endtask

  task automatic t_xlat();
    do_reset();
    set_mode(0, 1, 0, 0);
    run_pattern("R2 window factor", 6, 3);
    set_mode(0, 0, 1, 0);
    run_pattern("R2 bank factor", 3, 3);
  endtask

  task automatic t_fast();
    do_reset();
    set_mode(0, 1, 1, 1);
    run_pattern("R3 fast factor", 4, 2);
  endtask

  task automatic t_slow();
    logic p;
    do_reset();
    set_mode(0, 0, 0, 0);
    access(p); check("R1 first access", p, 1'b0);
    set_mode(1, 1, 1, 0);
    for (int i = 0; i < 3; i++) begin
      access(p); check("R1 slow no pulse", p, 1'b0);
    end
    set_mode(0, 0, 0, 0);
    access(p); check("R1 count kept through slow", p, 1'b1);
  endtask

  task automatic t_exceed();
    logic p;
    do_reset();
    set_mode(0, 1, 0, 0);
    access(p); check("R5 pre 1", p, 1'b0);
    access(p); check("R5 pre 2", p, 1'b0);
    set_mode(0, 1, 0, 1);
    access(p); check("R5 exceed after factor drop", p, 1'b1);
    access(p); check("R7 restart after pulse", p, 1'b0);
    access(p); check("R7 next full period", p, 1'b1);
  endtask

  task automatic t_width();
    logic p;
    do_reset();
    set_mode(0, 0, 0, 0);
    @(negedge clk);
    acc_stb = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(posedge clk);
      #1 check("R7 back-to-back pattern", extra_clk, (i % 2) == 0);
    end
    @(negedge clk);
    acc_stb = 1'b0;
    @(posedge clk);
    #1 check("R6 pulse one cycle", extra_clk, 1'b0);
    access(p); check("R6 idle then access", p, 1'b0);
  endtask

  task automatic t_reset_mid();
    logic p;
    do_reset();
    set_mode(0, 0, 0, 0);
    access(p);
    @(negedge clk); io_wait_set = 1'b1;
    @(negedge clk); io_wait_set = 1'b0;
    check("R9 set before reset", io_wait, 1'b1);
    do_reset();
    #1;
    check("R8 reset clears io_wait", io_wait, 1'b0);
    access(p); check("R8 counter cleared", p, 1'b0);
    access(p); check("R8 full period after reset", p, 1'b1);
  endtask

  task automatic t_iowait();
    logic p;
    do_reset();
    set_mode(0, 0, 0, 0);
    @(negedge clk); io_wait_set = 1'b1;
    @(negedge clk); io_wait_set = 1'b0;
    check("R9 set", io_wait, 1'b1);
    set_mode(1, 0, 0, 0);
    access(p);
    check("R9 slow access keeps flag", io_wait, 1'b1);
    set_mode(0, 0, 0, 0);
    access(p);
    check("R9 counted access clears", io_wait, 1'b0);
    @(negedge clk); io_wait_set = 1'b1; acc_stb = 1'b1;
    @(negedge clk); io_wait_set = 1'b0; acc_stb = 1'b0;
    check("R9 set wins over clear", io_wait, 1'b1);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; acc_stb = 1'b0; slow_clk = 1'b0; win_en = 1'b0;
    bank_en = 1'b0; fast_xlat = 1'b0; io_wait_set = 1'b0;
    repeat (2) @(posedge clk);
    t_reset();
    t_plain();
    t_xlat();
    t_fast();
    t_slow();
    t_exceed();
    t_width();
    t_reset_mid();
    t_iowait();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule